// File: doc/BRIEF.md
# Qualified Bus Access Trace Recorder

This block watches the CPU bus one cycle at a time and records each data access into a small circular trace memory. A cycle qualifies when it is a memory access or a register access. Idle cycles and opcode fetches never reach the memory. Each stored row holds the full address and the data, plus two flag bits that give the access width (word or byte) and its direction (read or write). For a byte access only the low data byte is kept, and the high byte of the row is zeroed.

Capture runs only while the enable input is high, and at most one row is written per clock, in bus order. Software or a debug port reads rows back through an index, where index 0 is always the oldest row held. A fill count and a full flag show how many rows are held. When the memory is full, further accesses are dropped, unless wrap mode is selected; in wrap mode the newest row overwrites the oldest.

Top module: `acc_trace_top`

## Requirements
- R1: A cycle is recorded only when `bus_type` is 2 (memory access) or 3 (register access); type 0 (idle) and type 1 (opcode fetch) leave the fill count and the stored rows unchanged.
- R2: A stored row is `{word, read, addr[15:0], data[15:0]}`: bit 33 is 1 for a word access, bit 32 is 1 for a read, bits 31:16 are the address and bits 15:0 are the data.
- R3: For a byte access (`bus_word`=0), bits 15:8 of the stored row are zero and bits 7:0 equal `bus_data[7:0]`.
- R4: While `trc_en` is low no row is written and the fill count holds, whatever the cycle type.
- R5: Rows are written at most one per clock, in bus order; `rd_idx`=0 returns the oldest row held, and rows are returned combinationally in the same cycle.
- R6: With `wrap_en` low, the fill count stops at 32 and `full` goes high; later qualifying accesses are dropped and the stored rows stay unchanged.
- R7: With `wrap_en` high and the memory full, each qualifying access overwrites the oldest row; the count stays at 32 and `rd_idx`=0 returns the oldest row remaining.
- R8: After reset, `fill_cnt` is 0 and `full` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trc_en | input | 1 | Capture enable |
| wrap_en | input | 1 | Overwrite the oldest row when full |
| bus_type | input | 2 | Cycle type: 0 idle, 1 opcode fetch, 2 memory, 3 register |
| bus_addr | input | 16 | Access address |
| bus_data | input | 16 | Access data |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_read | input | 1 | 1 = read, 0 = write |
| rd_idx | input | 5 | Readback index, 0 = oldest row |
| rd_row | output | 34 | Row selected by `rd_idx` |
| fill_cnt | output | 6 | Number of rows held |
| full | output | 1 | Memory holds 32 rows |

## Verification
A write pointer that slips or a count that drifts shows up at once at the fill count and, in the next readback, as rows that are out of order or missing. A qualifier that passes idle or fetch cycles raises the count one cycle after the stray cycle. A wrong oldest-row base after a wrap shows up only once the memory has been full, so the bench fills the memory past 32 rows in both modes and then reads back every row. The field layout and the byte masking are swept over every combination of type, width and direction.

// File: rtl/acc_trace_pkg.sv
package acc_trace_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_FETCH = 2'd1,
      CYC_MEM   = 2'd2,
      CYC_REG   = 2'd3
   } cyc_t;

   function automatic logic cyc_traced(input cyc_t c);
      return (c == CYC_MEM) || (c == CYC_REG);
   endfunction
endpackage

// File: rtl/acc_trace_fmt.sv
module acc_trace_fmt
   import acc_trace_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16,
   localparam int ROWW = AW + DW + 2
) (
   input  logic            en,
   input  logic [1:0]      bus_type,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_data,
   input  logic            bus_word,
   input  logic            bus_read,
   output logic            qual,
   output logic [ROWW-1:0] row
);
   localparam int HB = DW / 2;

   logic [DW-1:0] data_kept;

   generate
      if (DW % 2 != 0) begin : g_bad_dw
         $error("acc_trace_fmt: DW must be even");
      end
      if (DW > 8) begin : g_mask_wide
         assign data_kept = bus_word ? bus_data
                                     : {{(DW-HB){1'b0}}, bus_data[HB-1:0]};
      end else begin : g_mask_narrow
         assign data_kept = bus_data;
      end
   endgenerate

   assign qual = en && cyc_traced(cyc_t'(bus_type));
   assign row  = {bus_word, bus_read, bus_addr, data_kept};
endmodule

// File: rtl/acc_trace_ring.sv
module acc_trace_ring #(
   parameter int ROWW     = 34,
   parameter int DEPTH    = 32,
   parameter bit REG_READ = 1'b0,
   localparam int IW = $clog2(DEPTH),
   localparam int CW = IW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_req,
   input  logic [ROWW-1:0] wr_row,
   input  logic            wrap_en,
   input  logic [IW-1:0]   rd_idx,
   output logic [ROWW-1:0] rd_row,
   output logic [CW-1:0]   fill_cnt,
   output logic            full
);
   logic [ROWW-1:0] mem [DEPTH];
   logic [IW-1:0]   wptr;
   logic [CW-1:0]   cnt;
   logic            is_full;
   logic            wr_go;
   logic [IW-1:0]   base;
   logic [IW-1:0]   phys;

   generate
      if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
         $error("acc_trace_ring: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   assign is_full = (cnt == CW'(DEPTH));
   assign wr_go   = wr_req && (!is_full || wrap_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         cnt  <= '0;
      end else if (wr_go) begin
         wptr <= wptr + 1'b1;
         if (!is_full) cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_go) mem[wptr] <= wr_row;
   end

   // oldest row sits at the write pointer once the ring has filled
   assign base = is_full ? wptr : '0;
   assign phys = base + rd_idx;

   generate
      if (REG_READ) begin : g_rd_reg
         always_ff @(posedge clk) rd_row <= mem[phys];
      end else begin : g_rd_comb
         assign rd_row = mem[phys];
      end
   endgenerate

   assign fill_cnt = cnt;
   assign full     = is_full;

   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fill_cnt <= CW'(DEPTH));

   assert_full_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> full);

   assert_one_per_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (fill_cnt == $past(fill_cnt) || fill_cnt == $past(fill_cnt) + 1'b1));
endmodule

// File: rtl/acc_trace_top.sv
module acc_trace_top #(
   parameter int AW       = 16,
   parameter int DW       = 16,
   parameter int DEPTH    = 32,
   parameter bit REG_READ = 1'b0,
   localparam int ROWW = AW + DW + 2,
   localparam int IW   = $clog2(DEPTH),
   localparam int CW   = IW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trc_en,
   input  logic            wrap_en,
   input  logic [1:0]      bus_type,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_data,
   input  logic            bus_word,
   input  logic            bus_read,
   input  logic [IW-1:0]   rd_idx,
   output logic [ROWW-1:0] rd_row,
   output logic [CW-1:0]   fill_cnt,
   output logic            full
);
   logic            qual;
   logic [ROWW-1:0] row;

   acc_trace_fmt #(.AW(AW), .DW(DW)) u_fmt (
      .en       (trc_en),
      .bus_type (bus_type),
      .bus_addr (bus_addr),
      .bus_data (bus_data),
      .bus_word (bus_word),
      .bus_read (bus_read),
      .qual     (qual),
      .row      (row)
   );

   acc_trace_ring #(.ROWW(ROWW), .DEPTH(DEPTH), .REG_READ(REG_READ)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_req   (qual),
      .wr_row   (row),
      .wrap_en  (wrap_en),
      .rd_idx   (rd_idx),
      .rd_row   (rd_row),
      .fill_cnt (fill_cnt),
      .full     (full)
   );

   assert_skip_untraced_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_type < 2'd2) |=> $stable(fill_cnt));

   assert_idle_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !trc_en |=> $stable(fill_cnt));

   generate
      if (!REG_READ && DW > 8) begin : g_chk_byte
         assert_byte_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_cnt > CW'(rd_idx) && !rd_row[ROWW-1]) |-> (rd_row[DW-1:DW/2] == '0));
      end
   endgenerate
endmodule

// File: tb/acc_trace_top_tb.sv
module acc_trace_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trc_en = 1'b0;
   logic        wrap_en = 1'b0;
   logic [1:0]  bus_type = 2'd0;
   logic [15:0] bus_addr = '0;
   logic [15:0] bus_data = '0;
   logic        bus_word = 1'b0;
   logic        bus_read = 1'b0;
   logic [4:0]  rd_idx = '0;
   logic [33:0] rd_row;
   logic [5:0]  fill_cnt;
   logic        full;

   int n_chk = 0;
   int n_bad = 0;
   logic [33:0] exp_row [32];
   int exp_n = 0;
   int seq = 0;

   always #2.5 clk = ~clk;

   acc_trace_top u_dut (
      .clk(clk), .rst_n(rst_n), .trc_en(trc_en), .wrap_en(wrap_en),
      .bus_type(bus_type), .bus_addr(bus_addr), .bus_data(bus_data),
      .bus_word(bus_word), .bus_read(bus_read), .rd_idx(rd_idx),
      .rd_row(rd_row), .fill_cnt(fill_cnt), .full(full)
   );

   task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one bus cycle: drive at negedge, capture at posedge, settle after it
   task automatic step(input logic en, input logic [1:0] t, input logic w, input logic r);
      logic [15:0] a, d;
      logic [33:0] er;
      @(negedge clk);
      a = 16'h1000 + 16'(seq * 37);
      d = 16'hA5C3 ^ 16'(seq * 16'h0101);
      seq++;
      trc_en = en; bus_type = t; bus_word = w; bus_read = r;
      bus_addr = a; bus_data = d;
      er = {w, r, a, w ? d : {8'h00, d[7:0]}};
      if (en && t >= 2'd2) begin
         if (exp_n < 32) begin
            exp_row[exp_n] = er;
            exp_n++;
         end else if (wrap_en) begin
            for (int k = 0; k < 31; k++) exp_row[k] = exp_row[k+1];
            exp_row[31] = er;
         end
      end
      @(posedge clk);
      #1;
   endtask

   task automatic check_rows(input string req);
      @(negedge clk);
      trc_en = 1'b0; bus_type = 2'd0;
      for (int k = 0; k < exp_n; k++) begin
         @(negedge clk);
         rd_idx = 5'(k);
         #1;
         check(req, rd_row, exp_row[k]);
      end
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #12;
      check("R8 fill_cnt", 34'(fill_cnt), 34'd0);
      check("R8 full", 34'(full), 34'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1/R2/R3: sweep every type, width and direction
      for (int i = 0; i < 16; i++) begin
         step(1'b1, 2'(i), i[2], i[3]);
         check("R1 fill_cnt", 34'(fill_cnt), 34'(exp_n));
      end
      // R4: enable low, qualifying cycles ignored
      for (int i = 0; i < 8; i++) begin
         step(1'b0, 2'(2 + i % 2), i[0], i[1]);
         check("R4 fill_cnt", 34'(fill_cnt), 34'(exp_n));
      end
      check_rows("R2/R3/R5 rows");

      // R6: overfill with wrap off
      for (int i = 0; i < 40; i++) begin
         step(1'b1, 2'(2 + i % 2), i[1], i[2]);
         check("R6 fill_cnt", 34'(fill_cnt), 34'(exp_n));
      end
      check("R6 full", 34'(full), 34'd1);
      check_rows("R6 rows kept");

      // R7: wrap on, oldest overwritten
      @(negedge clk);
      wrap_en = 1'b1;
      for (int i = 0; i < 20; i++) begin
         step(1'b1, 2'(2 + i % 2), i[0], i[2]);
         check("R7 fill_cnt", 34'(fill_cnt), 34'd32);
      end
      check("R7 full", 34'(full), 34'd1);
      check_rows("R7 wrapped rows");

      // R8: reset again
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R8 fill_cnt after reset", 34'(fill_cnt), 34'd0);
      check("R8 full after reset", 34'(full), 34'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule